// File: doc/BRIEF.md
# Microcoded Memory-Interface Sequencer

This block produces the control waveforms for an external memory from a small writable microcode store. Each 32-bit microcode word describes one bus step. A step lasts four cycles of the block clock, and that clock runs at four times the memory bus rate. In every step the word sets the levels of six general-purpose control lines for the whole step. It also sets the chip-select line and the byte-select line separately for each quarter of the step, so select edges can be placed at quarter-step resolution.

A host loads the store through a simple write port while the sequencer is idle. A sequence starts from one of five request inputs, and each request has its own fixed entry index:

- a bank-matched read access;
- a bank-matched write access;
- a refresh timer expiry;
- an exception (transfer error or reset);
- a software run command, which supplies its own entry index.

Requests that arrive together, or that arrive while a sequence is running, are latched as pending. They are served one at a time in a fixed priority order.

From the entry index the sequencer walks forward one word per step until it reaches a word marked as the last one. A word can enable waiting on an external wait input. While that input is high, the current word is repeated and the index stays where it is.

Top module: `ucseq_mem_seq`

## Requirements
- R1: A host write (`host_we` high at a clock edge) stores `host_wdata` at index `host_addr` only when `busy` is low at that edge. A write issued while `busy` is high is discarded, and later runs of that index produce the earlier word.
- R2: The entry indices are 0x00 for a read access (`acc_req` with `acc_wr`=0), 0x18 for a write access (`acc_req` with `acc_wr`=1), 0x30 for refresh, 0x3C for exception, and the value of `run_idx` captured with `run_req` for a software run.
- R3: Pending requests are granted in this order: exception first, then refresh, then read access, then write access, then software run. Each following sequence starts at the clock edge right after the edge that ends the previous one.
- R4: The microcode word layout is as follows. Bits [3:0] are the chip-select level for quarters 0..3, with bit q for quarter q. Bits [7:4] are the byte-select level for quarters 0..3, with bit 4+q for quarter q. Bits [13:8] are the general-purpose line levels. Bit 14 is wait-enable and bit 15 is last. Bits [31:16] are reserved and have no effect on any output.
- R5: Let S be the edge at which `busy` rises. The pins show quarter q of step k during the cycle after edge S+2+4k+q. `mem_gpl` stays constant across the four quarters of a step.
- R6: After a step whose word has last=0 (and is not held), the next step executes index+1, wrapping from 0x3F to 0x00. After a step whose word has last=1, `busy` falls at the edge that outputs that step's quarter 3.
- R7: `mem_wait` passes through a two-stage synchronizer and is sampled in quarter 2 of every step whose word has wait-enable set. A sampled high repeats the same word in the next step with the index unchanged.
- R8: Reset is synchronous and active high. After reset, and in every cycle that follows a cycle with `busy` low, `mem_cs`, `mem_bs` and all bits of `mem_gpl` are 1.
- R9: A request that arrives while a sequence is running is held pending and runs after that sequence ends, at the entry index of its type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, four times the bus step rate |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Microcode write strobe |
| host_addr | input | 6 | Microcode write index |
| host_wdata | input | 32 | Microcode word to store |
| acc_req | input | 1 | Bank-matched access request pulse |
| acc_wr | input | 1 | Direction of the access request, 1 for write |
| rfsh_req | input | 1 | Refresh timer expiry pulse |
| exc_req | input | 1 | Exception request pulse |
| run_req | input | 1 | Software run command pulse |
| run_idx | input | 6 | Entry index for the software run command |
| mem_wait | input | 1 | Asynchronous wait input from the memory |
| busy | output | 1 | High from sequence start until the last step completes |
| mem_cs | output | 1 | Chip-select line level |
| mem_bs | output | 1 | Byte-select line level |
| mem_gpl | output | 6 | General-purpose control line levels |

## Verification
The assertions assume the following about the stimulus:
- Request inputs are single-cycle pulses.
- The host does not write in a cycle where a request is pending while the sequencer is idle, because such a write postpones the start by one cycle and would move every quarter by one edge.
- `mem_wait` stays low unless a test deliberately holds a wait-enabled word.

The stimulus keeps to these assumptions. It loads the whole store while idle, then sweeps the software run entry over all 64 indices so that every word and the index wrap are executed. Waiting is tested only on a dedicated sequence, and the wait input is released at a known quarter so that the number of repeats is fixed.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int QTR     = 4;
  localparam int PH_W    = $clog2(QTR);
  localparam int GPL_W   = 6;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic [15:0]      rsvd;
    logic             last;
    logic             wen;
    logic [GPL_W-1:0] gpl;
    logic [QTR-1:0]   bs;
    logic [QTR-1:0]   cs;
  } uword_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_RUN} seq_st_t;
endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ucseq_ctrl.sv
module ucseq_ctrl
  import ucseq_pkg::*;
#(
  parameter int            AW     = 6,
  parameter logic [AW-1:0] ENT_RD = 'h00,
  parameter logic [AW-1:0] ENT_WR = 'h18,
  parameter logic [AW-1:0] ENT_RF = 'h30,
  parameter logic [AW-1:0] ENT_EX = 'h3C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic            acc_req,
  input  logic            acc_wr,
  input  logic            rfsh_req,
  input  logic            exc_req,
  input  logic            run_req,
  input  logic [AW-1:0]   run_idx,
  input  logic            mem_wait,
  input  logic            cur_wen,
  input  logic            cur_last,
  output logic [AW-1:0]   idx_d,
  output logic [AW-1:0]   idx_q,
  output logic [PH_W-1:0] ph,
  output logic            running,
  output logic            load_word,
  output logic            busy,
  output logic            wait_s
);
  // request slots, lowest slot number wins
  localparam int NREQ  = 5;
  localparam int S_EX  = 0;
  localparam int S_RF  = 1;
  localparam int S_RD  = 2;
  localparam int S_WR  = 3;
  localparam int S_RUN = 4;
  localparam logic [PH_W-1:0] PH_DEC  = PH_W'(QTR - 2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(QTR - 1);

  seq_st_t        st;
  logic [NREQ-1:0] req_in, pend, gnt, clr;
  logic [AW-1:0]  run_idx_q, entry;
  logic           start, decide, hold, done_q, ws1;

  assign req_in[S_EX]  = exc_req;
  assign req_in[S_RF]  = rfsh_req;
  assign req_in[S_RD]  = acc_req & ~acc_wr;
  assign req_in[S_WR]  = acc_req &  acc_wr;
  assign req_in[S_RUN] = run_req;

  always_comb begin
    gnt = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (pend[i]) gnt = NREQ'(1) << i;
    end
  end

  assign start = (st == ST_IDLE) && (|pend) && !host_we;
  assign clr   = start ? gnt : '0;

  genvar g;
  generate
    for (g = 0; g < NREQ; g++) begin : g_pend
      always_ff @(posedge clk) begin
        if (rst) pend[g] <= 1'b0;
        else     pend[g] <= (pend[g] & ~clr[g]) | req_in[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          run_idx_q <= '0;
    else if (run_req) run_idx_q <= run_idx;
  end

  always_comb begin
    entry = run_idx_q;
    if      (gnt[S_EX]) entry = ENT_EX;
    else if (gnt[S_RF]) entry = ENT_RF;
    else if (gnt[S_RD]) entry = ENT_RD;
    else if (gnt[S_WR]) entry = ENT_WR;
  end

  // wait input synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      ws1    <= 1'b0;
      wait_s <= 1'b0;
    end else begin
      ws1    <= mem_wait;
      wait_s <= ws1;
    end
  end

  assign running = (st == ST_RUN);
  assign busy    = (st != ST_IDLE);
  assign decide  = running && (ph == PH_DEC);
  assign hold    = cur_wen && wait_s;

  always_comb begin
    idx_d = idx_q;
    if (start)                            idx_d = entry;
    else if (decide && !hold && !cur_last) idx_d = idx_q + 1'b1;
  end

  assign load_word = (st == ST_START) || (running && (ph == PH_LAST) && !done_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ph     <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      if (start)       done_q <= 1'b0;
      else if (decide) done_q <= !hold && cur_last;
      case (st)
        ST_IDLE:  if (start) st <= ST_START;
        ST_START: begin
          st <= ST_RUN;
          ph <= '0;
        end
        default: begin
          ph <= ph + 1'b1;
          if (ph == PH_LAST && done_q) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ucseq_wave.sv
module ucseq_wave
  import ucseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_word,
  input  logic              running,
  input  logic [PH_W-1:0]   ph,
  input  logic [WORD_W-1:0] rdata,
  output logic              cur_wen,
  output logic              cur_last,
  output logic              mem_cs,
  output logic              mem_bs,
  output logic [GPL_W-1:0]  mem_gpl
);
  uword_t cur;

  // timing stage: latch the fetched word
  always_ff @(posedge clk) begin
    if (rst)            cur <= '0;
    else if (load_word) cur <= uword_t'(rdata);
  end

  assign cur_wen  = cur.wen;
  assign cur_last = cur.last;

  // registered pins, one quarter bit per phase
  always_ff @(posedge clk) begin
    if (rst || !running) begin
      mem_cs  <= 1'b1;
      mem_bs  <= 1'b1;
      mem_gpl <= '1;
    end else begin
      mem_cs  <= cur.cs[ph];
      mem_bs  <= cur.bs[ph];
      mem_gpl <= cur.gpl;
    end
  end
endmodule

// File: rtl/ucseq_mem_seq.sv
module ucseq_mem_seq
  import ucseq_pkg::*;
#(
  parameter int            AW     = 6,
  parameter logic [AW-1:0] ENT_RD = 'h00,
  parameter logic [AW-1:0] ENT_WR = 'h18,
  parameter logic [AW-1:0] ENT_RF = 'h30,
  parameter logic [AW-1:0] ENT_EX = 'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              rfsh_req,
  input  logic              exc_req,
  input  logic              run_req,
  input  logic [AW-1:0]     run_idx,
  input  logic              mem_wait,
  output logic              busy,
  output logic              mem_cs,
  output logic              mem_bs,
  output logic [GPL_W-1:0]  mem_gpl
);
  logic [AW-1:0]     idx_d, idx_q;
  logic [PH_W-1:0]   ph;
  logic              running, load_word, wait_s, cur_wen, cur_last, store_we;
  logic [WORD_W-1:0] rdata;

  assign store_we = host_we && !busy;

  ucseq_store #(.AW(AW), .DW(WORD_W)) store_i (
    .clk(clk), .we(store_we), .waddr(host_addr), .wdata(host_wdata),
    .raddr(idx_d), .rdata(rdata)
  );

  ucseq_ctrl #(
    .AW(AW), .ENT_RD(ENT_RD), .ENT_WR(ENT_WR), .ENT_RF(ENT_RF), .ENT_EX(ENT_EX)
  ) ctrl_i (
    .clk(clk), .rst(rst), .host_we(host_we),
    .acc_req(acc_req), .acc_wr(acc_wr), .rfsh_req(rfsh_req),
    .exc_req(exc_req), .run_req(run_req), .run_idx(run_idx),
    .mem_wait(mem_wait), .cur_wen(cur_wen), .cur_last(cur_last),
    .idx_d(idx_d), .idx_q(idx_q), .ph(ph), .running(running),
    .load_word(load_word), .busy(busy), .wait_s(wait_s)
  );

  ucseq_wave wave_i (
    .clk(clk), .rst(rst), .load_word(load_word), .running(running),
    .ph(ph), .rdata(rdata), .cur_wen(cur_wen), .cur_last(cur_last),
    .mem_cs(mem_cs), .mem_bs(mem_bs), .mem_gpl(mem_gpl)
  );
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk
  import ucseq_pkg::*;
#(
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             running,
  input logic [PH_W-1:0]  ph,
  input logic [AW-1:0]    idx_q,
  input logic             cur_wen,
  input logic             cur_last,
  input logic             wait_s,
  input logic             mem_cs,
  input logic             mem_bs,
  input logic [GPL_W-1:0] mem_gpl
);
  p_idle_pins_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (mem_cs && mem_bs && (mem_gpl == '1)));

  p_hold_on_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (running && ph == PH_W'(2) && cur_wen && wait_s) |=> (idx_q == $past(idx_q)));

  p_index_step_r6: assert property (@(posedge clk) disable iff (rst)
    (running && ph == PH_W'(2) && !(cur_wen && wait_s) && !cur_last)
      |=> (idx_q == AW'($past(idx_q) + 1'b1)));

  p_end_on_last_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(running && ph == PH_W'(3) && cur_last));

  p_quarter_walk_r5: assert property (@(posedge clk) disable iff (rst)
    (running && ph != PH_W'(3)) |=> (running && ph == PH_W'($past(ph) + 1'b1)));
endmodule

bind ucseq_mem_seq ucseq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .running(running), .ph(ph),
  .idx_q(idx_q), .cur_wen(cur_wen), .cur_last(cur_last), .wait_s(wait_s),
  .mem_cs(mem_cs), .mem_bs(mem_bs), .mem_gpl(mem_gpl)
);

// File: tb/ucseq_mem_seq_tb_top.sv
module ucseq_mem_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic acc_req = 0, acc_wr = 0, rfsh_req = 0, exc_req = 0, run_req = 0;
  logic [AW-1:0] run_idx = '0;
  logic mem_wait = 1'b0;
  logic busy, mem_cs, mem_bs;
  logic [5:0] mem_gpl;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] mir [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  ucseq_mem_seq dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .acc_req(acc_req), .acc_wr(acc_wr),
    .rfsh_req(rfsh_req), .exc_req(exc_req), .run_req(run_req),
    .run_idx(run_idx), .mem_wait(mem_wait), .busy(busy),
    .mem_cs(mem_cs), .mem_bs(mem_bs), .mem_gpl(mem_gpl)
  );

  // program: cs/bs/gpl from the index, last at 02,13,1B,31, wait-enable at 11
  function automatic logic [31:0] mkword(input int i);
    logic [5:0] a;
    logic [31:0] w;
    a = i[5:0];
    w = '0;
    w[3:0]   = a[3:0];
    w[7:4]   = a[5:2] ^ 4'h9;
    w[13:8]  = a ^ 6'h2A;
    w[14]    = (a == 6'h11);
    w[15]    = (a == 6'h02) || (a == 6'h13) || (a == 6'h1B) || (a == 6'h31);
    w[31:16] = 16'hA5A5 ^ {10'd0, a};
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_we = 1'b0;
  endtask

  // called at a negedge; request is sampled at the next edge
  task automatic pulse(input bit ex, input bit rf, input bit acc, input bit wr,
                       input bit run, input logic [AW-1:0] ridx);
    exc_req = ex; rfsh_req = rf; acc_req = acc; acc_wr = wr;
    run_req = run; run_idx = ridx;
    @(posedge clk); @(negedge clk);
    exc_req = 0; rfsh_req = 0; acc_req = 0; acc_wr = 0; run_req = 0;
  endtask

  // follows one sequence from its start edge; checks every quarter (R4, R5, R6, R7)
  task automatic follow(input logic [AW-1:0] entry, input int drop_at,
                        input bit started, output int steps);
    logic [AW-1:0] ix;
    logic [31:0] w;
    bit done;
    bit used;
    ix = entry; done = 0; steps = 0;
    if (!started) begin
      @(posedge clk); @(negedge clk);
    end
    chk(busy === 1'b1, "R5", "busy after start", {31'd0, busy}, 32'd1);
    chk(mem_cs === 1'b1 && mem_gpl === 6'h3F, "R8", "pins idle before first quarter",
        {25'd0, mem_cs, mem_gpl}, {25'd0, 1'b1, 6'h3F});
    @(posedge clk);
    while (!done && steps < 200) begin
      used = mem_wait;
      w = mir[ix];
      for (int q = 0; q < 4; q++) begin
        @(posedge clk); @(negedge clk);
        chk(mem_cs === w[q] && mem_bs === w[4+q] && mem_gpl === w[13:8],
            "R4", $sformatf("pins idx %0h quarter %0d", ix, q),
            {24'd0, mem_cs, mem_bs, mem_gpl}, {24'd0, w[q], w[4+q], w[13:8]});
        if (q == 0) begin
          chk(busy === 1'b1, "R6", "busy during step", {31'd0, busy}, 32'd1);
          if (steps == drop_at) mem_wait = 1'b0;
        end
      end
      if (w[14] && used) ix = ix;
      else if (w[15])    done = 1;
      else               ix = ix + 1'b1;
      steps++;
    end
    chk(busy === 1'b0, "R6", "busy low after last quarter", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    int st;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && mem_cs === 1'b1 && mem_bs === 1'b1 && mem_gpl === 6'h3F,
        "R8", "reset state", {24'd0, busy, mem_cs, mem_bs, mem_gpl},
        {24'd0, 1'b0, 1'b1, 1'b1, 6'h3F});

    for (int i = 0; i < DEPTH; i++) begin
      mir[i] = mkword(i);
      host_write(AW'(i), mir[i]);
    end

    // R2 entry points
    pulse(0, 0, 1, 0, 0, '0); follow(6'h00, -1, 0, st);
    chk(st == 3, "R2", "read entry step count", st, 3);
    pulse(0, 0, 1, 1, 0, '0); follow(6'h18, -1, 0, st);
    chk(st == 4, "R2", "write entry step count", st, 4);
    pulse(0, 1, 0, 0, 0, '0); follow(6'h30, -1, 0, st);
    chk(st == 2, "R2", "refresh entry step count", st, 2);
    // exception walks 3C..3F then wraps to 00..02 (R6)
    pulse(1, 0, 0, 0, 0, '0); follow(6'h3C, -1, 0, st);
    chk(st == 7, "R6", "exception wrap step count", st, 7);

    // R2 software run swept over every entry index
    for (int i = 0; i < DEPTH; i++) begin
      pulse(0, 0, 0, 0, 1, AW'(i));
      follow(AW'(i), -1, 0, st);
    end

    // R7 wait: word 11 repeats while wait was high at the start of the step
    mem_wait = 1'b1;
    repeat (4) @(negedge clk);
    pulse(0, 0, 0, 0, 1, 6'h10);
    follow(6'h10, 3, 0, st);
    chk(st == 7, "R7", "held sequence step count", st, 7);

    // R3 priority with four simultaneous requests
    pulse(1, 1, 1, 0, 1, 6'h20);
    follow(6'h3C, -1, 0, st);
    follow(6'h30, -1, 0, st);
    follow(6'h00, -1, 0, st);
    follow(6'h20, -1, 0, st);
    chk(st == 18, "R3", "run served last", st, 18);

    // R9 request arriving at the start edge of a running sequence is held
    pulse(0, 1, 0, 0, 0, '0);
    pulse(0, 0, 1, 1, 0, '0);
    follow(6'h30, -1, 1, st);
    follow(6'h18, -1, 0, st);
    chk(st == 4, "R9", "pending write ran after refresh", st, 4);

    // R1 write while busy is discarded
    pulse(0, 1, 0, 0, 0, '0);
    @(posedge clk); @(negedge clk);
    host_write(6'h01, ~mkword(1));
    while (busy) @(negedge clk);
    @(negedge clk);
    pulse(0, 0, 1, 0, 0, '0); follow(6'h00, -1, 0, st);
    // R1 write while idle takes effect
    mir[1] = 32'h0000_3C5A;
    host_write(6'h01, mir[1]);
    pulse(0, 0, 1, 0, 0, '0); follow(6'h00, -1, 0, st);
    chk(st == 3, "R1", "updated word run", st, 3);

    @(negedge clk);
    chk(mem_cs === 1'b1 && mem_bs === 1'b1 && mem_gpl === 6'h3F, "R8", "idle pins",
        {25'd0, mem_cs, mem_gpl}, {25'd0, 1'b1, 6'h3F});
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule